// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit controller. It holds the accumulator and three status flags (carry, auxiliary carry, overflow) in registers. Each accepted operation combines the accumulator, the carry and an operand byte, and writes back only the state that operation owns. The parity flag is derived at all times from the accumulator. Logic operations can also target an external byte. In that case the result leaves on a result port and the accumulator stays untouched.

Operations arrive on a valid/ready input. The block completes every operation in one cycle, so `in_ready` is held high and the block never applies back-pressure. An operation is accepted on each rising clock edge where `in_valid` is high. Its effects are visible on the outputs after that edge. `res_valid` and `br_taken` are single-cycle pulses with no ready of their own, and a consumer must take them in the cycle they appear. Operand addressing is outside the block: whatever selected the byte presents it on `in_opnd` or `in_ext`.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `acc_o` is 0, `cy_o`, `ac_o`, `ov_o`, `par_o`, `res_valid` and `br_taken` are 0, and `res_data` is 0.
- R2: Opcodes 1, 2 and 3 (AND, OR, XOR) write accumulator op `in_opnd` into the accumulator and leave carry, auxiliary carry and overflow unchanged.
- R3: Opcodes 4, 5 and 6 (AND, OR, XOR on the external byte) put `in_ext` op `in_opnd` on `res_data`, with `res_valid` high for exactly the following cycle, and leave the accumulator and all flags unchanged.
- R4: Opcode 7 (add) and opcode 8 (add with carry-in CY) write the low 8 bits of the sum into the accumulator. Carry becomes the carry out of bit 7, auxiliary carry the carry out of bit 3, and overflow the signed two's-complement overflow of the sum.
- R5: Opcode 9 computes accumulator − `in_opnd` − CY into the accumulator. Carry becomes the borrow out of bit 7, auxiliary carry the borrow out of bit 3, and overflow the signed overflow of the difference.
- R6: Opcode 10 compares the accumulator with `in_opnd`, and opcode 11 compares `in_ext` with `in_opnd`. Neither writes the accumulator, auxiliary carry or overflow. Carry becomes 1 when the first value is below the second (unsigned). `br_taken` is high for the following cycle exactly when the two differ.
- R7: Opcode 12 clears the accumulator, opcode 13 inverts it and opcode 22 loads it with `in_opnd`. No flag changes.
- R8: Opcode 14 rotates the accumulator left by one, opcode 16 rotates it right by one and opcode 18 swaps its nibbles. No flag changes.
- R9: Opcode 15 rotates left through carry and opcode 17 rotates right through carry. The bit shifted out goes to carry, and the old carry fills the vacated bit. Auxiliary carry and overflow are unchanged.
- R10: Opcode 19 sets carry, opcode 20 clears it and opcode 21 inverts it. The accumulator and the other flags are unchanged.
- R11: `par_o` is 1 exactly when the accumulator holds an odd number of ones, and it changes in the same cycle as `acc_o`.
- R12: `in_ready` is always 1. A cycle with `in_valid` low, or an accepted opcode 0 or 23–31, changes no state, and `res_valid` and `br_taken` stay low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation accepted (always 1) |
| in_op | input | 5 | Opcode |
| in_opnd | input | DATA_W | Second operand byte |
| in_ext | input | DATA_W | External first-operand byte |
| acc_o | output | DATA_W | Accumulator |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag |
| ov_o | output | 1 | Overflow flag |
| par_o | output | 1 | Parity of the accumulator |
| res_valid | output | 1 | Pulse: `res_data` updated |
| res_data | output | DATA_W | Result of an external-byte logic operation |
| br_taken | output | 1 | Pulse: compared values differed |

## Verification
The bench builds the block with its default width of 8 bits. At that width the nibble boundary sits at bit 3 and the signed range is −128..127, so directed cases can place the operands exactly on the 0x7F/0x80 and 0x0F/0x10 edges. With 8-bit operands and a 5-bit opcode, random draws reach every opcode many times, including the unused codes 23–31. They also reach both carry-in values on add and subtract and both orderings of compare, including operands that are equal.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP  = 5'd0,
    OP_AND  = 5'd1,
    OP_OR   = 5'd2,
    OP_XOR  = 5'd3,
    OP_ANDX = 5'd4,
    OP_ORX  = 5'd5,
    OP_XORX = 5'd6,
    OP_ADD  = 5'd7,
    OP_ADDC = 5'd8,
    OP_SUBB = 5'd9,
    OP_CMPA = 5'd10,
    OP_CMPX = 5'd11,
    OP_CLRA = 5'd12,
    OP_CPLA = 5'd13,
    OP_RL   = 5'd14,
    OP_RLC  = 5'd15,
    OP_RR   = 5'd16,
    OP_RRC  = 5'd17,
    OP_SWAP = 5'd18,
    OP_SETC = 5'd19,
    OP_CLRC = 5'd20,
    OP_CPLC = 5'd21,
    OP_LDA  = 5'd22
  } alu_op_e;

  typedef enum logic [1:0] {
    CY_ARITH = 2'd0,
    CY_CMP   = 2'd1,
    CY_ROT   = 2'd2,
    CY_BIT   = 2'd3
  } cy_src_e;

  typedef struct packed {
    logic    wr_acc;
    logic    acc_from_arith;
    logic    wr_ext;
    logic    wr_cy;
    cy_src_e cy_src;
    logic    wr_acov;
    logic    is_cmp;
  } alu_ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [4:0] op,
  output alu_ctl_t   ctl
);

  always_comb begin
    ctl        = '0;
    ctl.cy_src = CY_ARITH;
    case (op)
      OP_AND, OP_OR, OP_XOR: ctl.wr_acc = 1'b1;
      OP_ANDX, OP_ORX, OP_XORX: ctl.wr_ext = 1'b1;
      OP_ADD, OP_ADDC, OP_SUBB: begin
        ctl.wr_acc         = 1'b1;
        ctl.acc_from_arith = 1'b1;
        ctl.wr_cy          = 1'b1;
        ctl.cy_src         = CY_ARITH;
        ctl.wr_acov        = 1'b1;
      end
      OP_CMPA, OP_CMPX: begin
        ctl.wr_cy  = 1'b1;
        ctl.cy_src = CY_CMP;
        ctl.is_cmp = 1'b1;
      end
      OP_CLRA, OP_CPLA, OP_RL, OP_RR, OP_SWAP, OP_LDA: ctl.wr_acc = 1'b1;
      OP_RLC, OP_RRC: begin
        ctl.wr_acc = 1'b1;
        ctl.wr_cy  = 1'b1;
        ctl.cy_src = CY_ROT;
      end
      OP_SETC, OP_CLRC, OP_CPLC: begin
        ctl.wr_cy  = 1'b1;
        ctl.cy_src = CY_BIT;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] ext,
  input  logic              cy,
  output logic [DATA_W-1:0] acc_res,
  output logic [DATA_W-1:0] ext_res,
  output logic              rot_cy,
  output logic              bit_cy
);

  localparam int NIB = DATA_W / 2;

  always_comb begin
    acc_res = acc;
    ext_res = ext;
    rot_cy  = cy;
    bit_cy  = cy;
    case (op)
      OP_AND:  acc_res = acc & opnd;
      OP_OR:   acc_res = acc | opnd;
      OP_XOR:  acc_res = acc ^ opnd;
      OP_ANDX: ext_res = ext & opnd;
      OP_ORX:  ext_res = ext | opnd;
      OP_XORX: ext_res = ext ^ opnd;
      OP_CLRA: acc_res = '0;
      OP_CPLA: acc_res = ~acc;
      OP_LDA:  acc_res = opnd;
      OP_RL:   acc_res = {acc[DATA_W-2:0], acc[DATA_W-1]};
      OP_RR:   acc_res = {acc[0], acc[DATA_W-1:1]};
      OP_RLC: begin
        acc_res = {acc[DATA_W-2:0], cy};
        rot_cy  = acc[DATA_W-1];
      end
      OP_RRC: begin
        acc_res = {cy, acc[DATA_W-1:1]};
        rot_cy  = acc[0];
      end
      OP_SWAP: acc_res = {acc[NIB-1:0], acc[DATA_W-1:NIB]};
      OP_SETC: bit_cy = 1'b1;
      OP_CLRC: bit_cy = 1'b0;
      OP_CPLC: bit_cy = ~cy;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] ext,
  input  logic              cy,
  output logic [DATA_W-1:0] res,
  output logic              cy_out,
  output logic              ac_out,
  output logic              ov_out,
  output logic              cmp_lt,
  output logic              cmp_ne
);

  localparam int NIB = DATA_W / 2;
  localparam int LOW = DATA_W - 1;

  logic              cin;
  logic              is_sub;
  logic [DATA_W:0]   add_full, sub_full;
  logic [NIB:0]      add_nib,  sub_nib;
  logic [LOW:0]      add_low,  sub_low;
  logic [DATA_W-1:0] cmp_a;

  assign is_sub = (op == OP_SUBB);
  assign cin    = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy : 1'b0;

  assign add_full = {1'b0, acc} + {1'b0, opnd} + {{DATA_W{1'b0}}, cin};
  assign add_nib  = {1'b0, acc[NIB-1:0]} + {1'b0, opnd[NIB-1:0]} + {{NIB{1'b0}}, cin};
  assign add_low  = {1'b0, acc[LOW-1:0]} + {1'b0, opnd[LOW-1:0]} + {{LOW{1'b0}}, cin};

  assign sub_full = {1'b0, acc} - {1'b0, opnd} - {{DATA_W{1'b0}}, cin};
  assign sub_nib  = {1'b0, acc[NIB-1:0]} - {1'b0, opnd[NIB-1:0]} - {{NIB{1'b0}}, cin};
  assign sub_low  = {1'b0, acc[LOW-1:0]} - {1'b0, opnd[LOW-1:0]} - {{LOW{1'b0}}, cin};

  always_comb begin
    if (is_sub) begin
      res    = sub_full[DATA_W-1:0];
      cy_out = sub_full[DATA_W];
      ac_out = sub_nib[NIB];
      ov_out = sub_low[LOW] ^ sub_full[DATA_W];
    end else begin
      res    = add_full[DATA_W-1:0];
      cy_out = add_full[DATA_W];
      ac_out = add_nib[NIB];
      ov_out = add_low[LOW] ^ add_full[DATA_W];
    end
  end

  assign cmp_a  = (op == OP_CMPX) ? ext : acc;
  assign cmp_lt = (cmp_a < opnd);
  assign cmp_ne = (cmp_a != opnd);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_op,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic [DATA_W-1:0] in_ext,
  output logic [DATA_W-1:0] acc_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              ov_o,
  output logic              par_o,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              br_taken
);

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] acc_q, res_q;
  logic              cy_q, ac_q, ov_q, rv_q, br_q;
  logic [DATA_W-1:0] lg_acc, lg_ext, ar_res;
  logic              lg_rot_cy, lg_bit_cy;
  logic              ar_cy, ar_ac, ar_ov, ar_lt, ar_ne;
  logic              cy_next;

  acc_alu_decode u_dec (.op(in_op), .ctl(ctl));

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op(in_op), .acc(acc_q), .opnd(in_opnd), .ext(in_ext), .cy(cy_q),
    .acc_res(lg_acc), .ext_res(lg_ext), .rot_cy(lg_rot_cy), .bit_cy(lg_bit_cy)
  );

  acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op(in_op), .acc(acc_q), .opnd(in_opnd), .ext(in_ext), .cy(cy_q),
    .res(ar_res), .cy_out(ar_cy), .ac_out(ar_ac), .ov_out(ar_ov),
    .cmp_lt(ar_lt), .cmp_ne(ar_ne)
  );

  always_comb begin
    case (ctl.cy_src)
      CY_ARITH: cy_next = ar_cy;
      CY_CMP:   cy_next = ar_lt;
      CY_ROT:   cy_next = lg_rot_cy;
      default:  cy_next = lg_bit_cy;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      cy_q  <= 1'b0;
      ac_q  <= 1'b0;
      ov_q  <= 1'b0;
      rv_q  <= 1'b0;
      br_q  <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      br_q <= 1'b0;
      if (in_valid) begin
        if (ctl.wr_acc) acc_q <= ctl.acc_from_arith ? ar_res : lg_acc;
        if (ctl.wr_ext) begin
          res_q <= lg_ext;
          rv_q  <= 1'b1;
        end
        if (ctl.wr_cy) cy_q <= cy_next;
        if (ctl.wr_acov) begin
          ac_q <= ar_ac;
          ov_q <= ar_ov;
        end
        if (ctl.is_cmp) br_q <= ar_ne;
      end
    end
  end

  assign in_ready  = 1'b1;
  assign acc_o     = acc_q;
  assign cy_o      = cy_q;
  assign ac_o      = ac_q;
  assign ov_o      = ov_q;
  assign par_o     = ^acc_q;
  assign res_valid = rv_q;
  assign res_data  = res_q;
  assign br_taken  = br_q;

  a_r2_logic_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR)
    |=> $stable(cy_q) && $stable(ac_q) && $stable(ov_q));

  a_r3_ext_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_op == OP_ANDX || in_op == OP_ORX || in_op == OP_XORX)
    |=> $stable(acc_q) && $stable(cy_q) && rv_q);

  a_r6_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_op == OP_CMPA || in_op == OP_CMPX)
    |=> $stable(acc_q) && $stable(ac_q) && $stable(ov_q));

  a_r6_branch_source: assert property (@(posedge clk) disable iff (!rst_n)
    br_q |-> $past(in_valid && (in_op == OP_CMPA || in_op == OP_CMPX)));

  a_r9_rlc_through_carry: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == OP_RLC
    |=> acc_q[0] == $past(cy_q) && cy_q == $past(acc_q[DATA_W-1]));

  a_r10_cpl_carry: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == OP_CPLC |=> cy_q != $past(cy_q));

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_q) && $stable(cy_q) && $stable(ac_q)
                  && $stable(ov_q) && !rv_q && !br_q);

endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [4:0]   in_op = '0;
  logic [W-1:0] in_opnd = '0, in_ext = '0;
  logic [W-1:0] acc_o, res_data;
  logic         cy_o, ac_o, ov_o, par_o, res_valid, br_taken;

  int n_chk = 0;
  int n_err = 0;

  int m_acc = 0, m_res = 0;
  int m_cy = 0, m_ac = 0, m_ov = 0, m_rv = 0, m_br = 0;

  always #4 clk = ~clk;

  acc_alu #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_opnd(in_opnd), .in_ext(in_ext), .acc_o(acc_o),
    .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .par_o(par_o),
    .res_valid(res_valid), .res_data(res_data), .br_taken(br_taken)
  );

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int odd_ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n % 2;
  endfunction

  function automatic string req_of(int op);
    case (op)
      1, 2, 3:     return "R2";
      4, 5, 6:     return "R3";
      7, 8:        return "R4";
      9:           return "R5";
      10, 11:      return "R6";
      12, 13, 22:  return "R7";
      14, 16, 18:  return "R8";
      15, 17:      return "R9";
      19, 20, 21:  return "R10";
      default:     return "R12";
    endcase
  endfunction

  task automatic model(int op, int b, int x);
    int a = m_acc;
    int c = m_cy;
    int s, ss, cin;
    m_rv = 0;
    m_br = 0;
    case (op)
      1: m_acc = a & b;
      2: m_acc = a | b;
      3: m_acc = a ^ b;
      4: begin m_res = x & b; m_rv = 1; end
      5: begin m_res = x | b; m_rv = 1; end
      6: begin m_res = x ^ b; m_rv = 1; end
      7, 8: begin
        cin   = (op == 8) ? c : 0;
        s     = a + b + cin;
        m_acc = s & 255;
        m_cy  = (s > 255) ? 1 : 0;
        m_ac  = (((a & 15) + (b & 15) + cin) > 15) ? 1 : 0;
        ss    = sgn(a) + sgn(b) + cin;
        m_ov  = (ss > 127 || ss < -128) ? 1 : 0;
      end
      9: begin
        s     = a - b - c;
        m_acc = s & 255;
        m_cy  = (s < 0) ? 1 : 0;
        m_ac  = (((a & 15) - (b & 15) - c) < 0) ? 1 : 0;
        ss    = sgn(a) - sgn(b) - c;
        m_ov  = (ss > 127 || ss < -128) ? 1 : 0;
      end
      10: begin m_cy = (a < b) ? 1 : 0; m_br = (a != b) ? 1 : 0; end
      11: begin m_cy = (x < b) ? 1 : 0; m_br = (x != b) ? 1 : 0; end
      12: m_acc = 0;
      13: m_acc = (~a) & 255;
      14: m_acc = ((a << 1) | (a >> 7)) & 255;
      15: begin m_acc = ((a << 1) | c) & 255; m_cy = a >> 7; end
      16: m_acc = (a >> 1) | ((a & 1) << 7);
      17: begin m_acc = (a >> 1) | (c << 7); m_cy = a & 1; end
      18: m_acc = ((a << 4) | (a >> 4)) & 255;
      19: m_cy = 1;
      20: m_cy = 0;
      21: m_cy = 1 - c;
      22: m_acc = b;
      default: ;
    endcase
  endtask

  task automatic check(string tag);
    logic [31:0] act, exp;
    act = {8'(acc_o), cy_o, ac_o, ov_o, par_o, res_valid, 8'(res_data), br_taken, 10'd0};
    exp = {8'(m_acc), 1'(m_cy), 1'(m_ac), 1'(m_ov), 1'(odd_ones(m_acc)),
           1'(m_rv), 8'(m_res), 1'(m_br), 10'd0};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: acc/cy/ac/ov/par/rv/res/br act=%h exp=%h (R11 parity incl.)",
               tag, act, exp);
    end
  endtask

  task automatic do_op(int op, int b, int x);
    in_valid = 1'b1;
    in_op    = 5'(op);
    in_opnd  = 8'(b);
    in_ext   = 8'(x);
    model(op, b, x);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req_of(op));
  endtask

  task automatic idle(int op, int b, int x);
    in_valid = 1'b0;
    in_op    = 5'(op);
    in_opnd  = 8'(b);
    in_ext   = 8'(x);
    m_rv = 0;
    m_br = 0;
    @(posedge clk);
    @(negedge clk);
    check("R12");
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd8051));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1");
    n_chk++;
    if (in_ready !== 1'b1) begin
      n_err++;
      $display("FAIL R12: in_ready act=%b exp=1", in_ready);
    end
    rst_n = 1'b1;

    // R4 signed overflow into 0x80, half carry
    do_op(22, 8'h7F, 0);
    do_op(7, 8'h01, 0);
    // R4 carry out from 0xFF
    do_op(22, 8'hFF, 0);
    do_op(7, 8'h01, 0);
    do_op(8, 8'h00, 0);          // R4 carry-in used
    // R5 borrow from zero, signed overflow at 0x80
    do_op(22, 8'h00, 0);
    do_op(20, 0, 0);
    do_op(9, 8'h01, 0);
    do_op(22, 8'h80, 0);
    do_op(20, 0, 0);
    do_op(9, 8'h01, 0);
    do_op(9, 8'h10, 0);
    // R6 equal, less, greater, external form
    do_op(22, 8'h42, 0);
    do_op(10, 8'h42, 0);
    do_op(10, 8'h43, 0);
    do_op(10, 8'h41, 0);
    do_op(11, 8'h90, 8'h10);
    do_op(11, 8'h55, 8'h55);
    // R9 rotates through carry, R8 swap, R10 carry ops
    do_op(19, 0, 0);
    do_op(22, 8'h5A, 0);
    do_op(15, 0, 0);
    do_op(17, 0, 0);
    do_op(18, 0, 0);
    do_op(21, 0, 0);
    do_op(21, 0, 0);
    // R3 external destination then idle pulse end
    do_op(4, 8'hF0, 8'h3C);
    idle(4, 8'hFF, 8'hFF);
    do_op(25, 8'hAA, 8'h55);     // R12 unused opcode
    do_op(13, 0, 0);             // R7
    do_op(12, 0, 0);             // R7

    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 7) == 0)
        idle(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
             int'($urandom_range(0, 255)));
      else
        do_op(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
              int'($urandom_range(0, 255)));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule